// File: doc/BRIEF.md
# Dot Column Brightness and Attribute Gate

This block stands between the character font stage and the column drivers of a multiplexed dot-matrix display. For every scan row it receives the raw column bits of the digits being driven, and it decides which of those columns are actually driven during each brightness sub-slot. Brightness comes from the width of the drive window inside a frame of fifteen sub-slots. The current per lit dot stays the same; only the on-time changes.

On top of the duty window, three attributes from the control word act on the columns. Per-digit flash cuts the columns of a flagged digit while the blink phase is low. Whole-display blink cuts every column while the phase is low. Lamp test lights every column at half duty, whatever the font data says. The result is registered and only changes on a sub-slot boundary. A scan controller outside the block supplies that boundary, the slot count and the blink phase.

Top module: `dot_col_gate`

## Requirements
- R1: While `rst_n` is low, `cols_out` is all zeros on the next clock edge.
- R2: `cols_out` changes only on the clock edge where `slot_tick` is high. On every other edge it holds its value, whatever the other inputs do.
- R3: The new value is taken from the inputs at the `slot_tick` edge and appears after that edge. With lamp test off and no attribute gating, column c is driven when `cols_in[c]` is 1 and `slot_idx` is below the active-slot count. The 3-bit brightness code `ctrl[2:0]` sets that count: 000 gives 15, 001 gives 12, 010 gives 8, 011 gives 6, 100 gives 4, 101 gives 3, 110 gives 2 and 111 gives 0 (out of 15 slots, numbered 0 to 14).
- R4: Brightness code 111 drives no column in any slot unless lamp test is on.
- R5: When `ctrl[3]` (flash enable) is 1 and `blink_on` is 0, digit d drives none of its columns if `flash_flags[d]` is 1. Digit d owns columns `cols_in[5d+4:5d]`. Digits whose flag is 0 are not affected.
- R6: When `ctrl[4]` (blink enable) is 1 and `blink_on` is 0, no column is driven, whatever the flash flags and flash enable are. When `blink_on` is 1, neither blink nor flash removes any column.
- R7: When `ctrl[6]` (lamp test) is 1, every column is driven in slots 0 to 7 and none is driven in slots 8 to 14. This holds whatever `cols_in`, the brightness code, blink and flash are.
- R8: `ctrl[5]` and `ctrl[7]` have no effect on `cols_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_tick | input | 1 | Sub-slot boundary strobe; the output updates only on edges where it is high |
| slot_idx | input | 4 | Current brightness sub-slot, 0 to 14 |
| cols_in | input | 20 | Raw font column bits, 5 per digit, 4 digits |
| flash_flags | input | 4 | Flash flag of each of the 4 digits |
| ctrl | input | 8 | Control word: [2:0] brightness, [3] flash enable, [4] blink enable, [6] lamp test |
| blink_on | input | 1 | Blink phase: 1 for the lit half, 0 for the dark half |
| cols_out | output | 20 | Gated column enables |

## Verification
Several rules are checked by assertions on every cycle: the output holds between slot boundaries, the output is cleared after reset, lamp test forces the fixed half-duty pattern, blank brightness and the dark blink half force zero, and no driven column lacks a raw font bit. The exact duty count for each brightness code, flash acting on single digits only, and the two spare control bits being ignored can only be shown by the bench. Its reference model steps through full slot frames for every code and attribute mix and compares the output on every clock.

// File: rtl/dot_col_gate_pkg.sv
// Package: shared control-word layout and duty arithmetic for the column gate.
// Assumes the control word bit positions are fixed by the decoder upstream.
package dot_col_gate_pkg;

    // Control word fields, MSB first; the positions are decoded by the register stage.
    typedef struct packed {
        logic       spare_hi;   // bit 7: not used by this gate
        logic       lamp_test;  // bit 6
        logic       spare_lo;   // bit 5: not used
        logic       blink_en;   // bit 4
        logic       flash_en;   // bit 3
        logic [2:0] level;      // bits 2..0: brightness code
    } ctrl_word_t;

    // Nominal percentage for each brightness code, 0 meaning blank.
    function automatic int unsigned level_percent(input logic [2:0] code);
        case (code)
            3'd0:    return 100;
            3'd1:    return 80;
            3'd2:    return 53;
            3'd3:    return 40;
            3'd4:    return 27;
            3'd5:    return 20;
            3'd6:    return 13;
            default: return 0;
        endcase
    endfunction

    // Active slots out of 'total', rounded to the nearest whole slot.
    function automatic int unsigned pct_to_slots(input int unsigned pct,
                                                 input int unsigned total);
        return (pct * total + 50) / 100;
    endfunction

endpackage

// File: rtl/gate_duty.sv
// gate_duty: decides whether the current brightness sub-slot lies inside the
// drive window. Lamp test replaces the programmed level with a fixed half duty.
// Assumes slot_idx counts 0..SLOTS-1; any higher value gives no drive.
module gate_duty #(
    parameter int unsigned SLOTS    = 15,
    parameter int unsigned LAMP_PCT = 50,
    localparam int unsigned SLOT_W  = $clog2(SLOTS + 1)
) (
    input  logic [2:0]        level,
    input  logic              lamp_test,
    input  logic [SLOT_W-1:0] slot_idx,
    output logic              drive_on
);
    import dot_col_gate_pkg::*;

    localparam int unsigned LAMP_SLOTS = pct_to_slots(LAMP_PCT, SLOTS);

    int unsigned window;

    // Pick the window length, then compare the slot against it.
    always_comb begin
        window   = lamp_test ? LAMP_SLOTS : pct_to_slots(level_percent(level), SLOTS);
        drive_on = 32'(slot_idx) < window;
    end

endmodule

// File: rtl/gate_digit_mask.sv
// gate_digit_mask: applies flash and blink to the columns of one digit.
// Lamp test overrides both and all font data: every column is offered.
// Assumes blink_on is already synchronous to clk.
module gate_digit_mask #(
    parameter int unsigned COLS = 5
) (
    input  logic [COLS-1:0] cols_in,
    input  logic            flash_flag,
    input  logic            flash_en,
    input  logic            blink_en,
    input  logic            blink_on,
    input  logic            lamp_test,
    output logic [COLS-1:0] cols_out
);
    logic dark;

    // A digit goes dark in the off phase if blink is on, or if it is flagged and flash is on.
    always_comb begin
        dark = !blink_on && (blink_en || (flash_en && flash_flag));
        if (lamp_test)
            cols_out = '1;
        else if (dark)
            cols_out = '0;
        else
            cols_out = cols_in;
    end

endmodule

// File: rtl/dot_col_gate.sv
// dot_col_gate: top of the column gate. Combines the per-digit attribute masks
// with the duty window and registers the result on sub-slot boundaries.
// Assumes slot_tick, slot_idx and blink_on come from one scan controller on clk.
module dot_col_gate #(
    parameter int unsigned DIGITS     = 4,
    parameter int unsigned COLS_PER_D = 5,
    parameter int unsigned SLOTS      = 15,
    localparam int unsigned NCOLS     = DIGITS * COLS_PER_D,
    localparam int unsigned SLOT_W    = $clog2(SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot_tick,
    input  logic [SLOT_W-1:0] slot_idx,
    input  logic [NCOLS-1:0]  cols_in,
    input  logic [DIGITS-1:0] flash_flags,
    input  logic [7:0]        ctrl,
    input  logic              blink_on,
    output logic [NCOLS-1:0]  cols_out
);
    import dot_col_gate_pkg::*;

    ctrl_word_t        cw;
    logic              drive_on;
    logic [NCOLS-1:0]  masked;
    logic [NCOLS-1:0]  next_cols;

    assign cw = ctrl_word_t'(ctrl);

    gate_duty #(.SLOTS(SLOTS), .LAMP_PCT(50)) u_duty (
        .level     (cw.level),
        .lamp_test (cw.lamp_test),
        .slot_idx  (slot_idx),
        .drive_on  (drive_on)
    );

    // One attribute mask per digit over its own column group.
    for (genvar d = 0; d < DIGITS; d++) begin : g_digit
        gate_digit_mask #(.COLS(COLS_PER_D)) u_mask (
            .cols_in    (cols_in[d*COLS_PER_D +: COLS_PER_D]),
            .flash_flag (flash_flags[d]),
            .flash_en   (cw.flash_en),
            .blink_en   (cw.blink_en),
            .blink_on   (blink_on),
            .lamp_test  (cw.lamp_test),
            .cols_out   (masked[d*COLS_PER_D +: COLS_PER_D])
        );
    end

    // Duty window gates the masked columns.
    always_comb next_cols = drive_on ? masked : '0;

    // Output register: cleared by reset, loaded only on a slot boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cols_out <= '0;
        else if (slot_tick)
            cols_out <= next_cols;
    end

    // R1: reset clears the output
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> cols_out == '0);

    // R2: no change between slot boundaries
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_tick |=> $stable(cols_out));

    // R3: a driven column always has its font bit, unless lamp test
    a_r3_subset: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_tick && !ctrl[6]) |=> (cols_out & ~$past(cols_in)) == '0);

    // R4: blank code gives no drive
    a_r4_blank: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_tick && !ctrl[6] && ctrl[2:0] == 3'b111) |=> cols_out == '0);

    // R6: dark blink half gives no drive
    a_r6_blink_dark: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_tick && !ctrl[6] && ctrl[4] && !blink_on) |=> cols_out == '0);

    // R7: lamp test lights all columns in the first 8 slots
    a_r7_lamp_on: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_tick && ctrl[6] && slot_idx < 8) |=> &cols_out);

    // R7: lamp test drives nothing in the remaining slots
    a_r7_lamp_off: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_tick && ctrl[6] && slot_idx >= 8) |=> cols_out == '0);

endmodule

// File: tb/dot_col_gate_bench.sv
// Bench: behavioural reference model compared against the gate on every clock.
module dot_col_gate_bench;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        slot_tick = 0;
    logic [3:0]  slot_idx = 0;
    logic [19:0] cols_in = 0;
    logic [3:0]  flash_flags = 0;
    logic [7:0]  ctrl = 0;
    logic        blink_on = 1;
    logic [19:0] cols_out;

    int    errors = 0;
    int    checks = 0;
    int    cycles = 0;
    bit    done = 0;
    string cur_req = "R1";
    logic [19:0] expect_q = 0;

    dot_col_gate u_dot_col_gate (
        .clk(clk), .rst_n(rst_n), .slot_tick(slot_tick), .slot_idx(slot_idx),
        .cols_in(cols_in), .flash_flags(flash_flags), .ctrl(ctrl),
        .blink_on(blink_on), .cols_out(cols_out)
    );

    always #2 clk = ~clk;

    // Reference: what the columns should be for one set of inputs.
    function automatic logic [19:0] model(input logic [3:0] s, input logic [19:0] c,
                                          input logic [3:0] ff, input logic [7:0] w,
                                          input logic bo);
        int active [8] = '{15, 12, 8, 6, 4, 3, 2, 0};
        logic [19:0] r;
        if (w[6]) return (s < 8) ? 20'hFFFFF : 20'h0;
        if (int'(s) >= active[w[2:0]]) return 20'h0;
        if (w[4] && !bo) return 20'h0;
        r = c;
        for (int d = 0; d < 4; d++)
            if (w[3] && ff[d] && !bo)
                for (int k = 0; k < 5; k++) r[d*5+k] = 1'b0;
        return r;
    endfunction

    // Model register, mirroring the one-edge update rule.
    always @(posedge clk) begin
        if (!rst_n) expect_q <= 20'h0;
        else if (slot_tick) expect_q <= model(slot_idx, cols_in, flash_flags, ctrl, blink_on);
    end

    // Compare on every falling edge.
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (cols_out !== expect_q) begin
                errors++;
                $display("FAIL %s: cols_out=%05h expected=%05h (slot %0d ctrl %02h)",
                         cur_req, cols_out, expect_q, slot_idx, ctrl);
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: cycles=%0d expected below 150000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    // One full frame of 15 slots; with gap, an idle cycle with new noise follows each tick.
    task automatic frame(input bit gap);
        for (int s = 0; s < 15; s++) begin
            slot_idx  = 4'(s);
            slot_tick = 1;
            cols_in   = 20'($urandom);
            @(negedge clk);
            if (gap) begin
                slot_tick = 0;
                cols_in   = 20'($urandom);
                slot_idx  = 4'($urandom);
                @(negedge clk);
            end
        end
        slot_tick = 0;
    endtask

    initial begin
        // R1: reset with noisy inputs
        cur_req = "R1";
        slot_tick = 1; cols_in = 20'hFFFFF; ctrl = 8'h40;
        repeat (3) @(negedge clk);
        slot_tick = 0;
        rst_n = 1;
        repeat (2) @(negedge clk);

        // R3: each brightness code over full frames
        cur_req = "R3";
        for (int lv = 0; lv < 7; lv++) begin
            ctrl = 8'(lv);
            frame(0); frame(0);
        end
        // R4: blank code
        cur_req = "R4";
        ctrl = 8'h07; frame(0); frame(1);

        // R2: ticks with idle cycles carrying changing inputs
        cur_req = "R2";
        ctrl = 8'h01; frame(1);
        ctrl = 8'h00; flash_flags = 4'hF; frame(1);

        // R5: flash on chosen digits, both blink phases
        cur_req = "R5";
        for (int p = 0; p < 16; p++) begin
            flash_flags = 4'(p);
            ctrl = 8'h08 | 8'(p % 3);
            blink_on = 0; frame(0);
            blink_on = 1; frame(0);
        end

        // R6: blink, alone and with flash
        cur_req = "R6";
        flash_flags = 4'b0101;
        for (int m = 0; m < 4; m++) begin
            ctrl = 8'h10 | (m[0] ? 8'h08 : 8'h00) | (m[1] ? 8'h02 : 8'h00);
            blink_on = 0; frame(0);
            blink_on = 1; frame(0);
        end

        // R7: lamp test over every level, blink and flash
        cur_req = "R7";
        for (int lv = 0; lv < 8; lv++) begin
            ctrl = 8'h58 | 8'(lv);
            blink_on = lv[0];
            frame(lv[1]);
        end

        // R8: spare bits 5 and 7 with several levels and attributes
        cur_req = "R8";
        for (int lv = 0; lv < 8; lv++) begin
            ctrl = 8'hA0 | 8'(lv) | (lv[0] ? 8'h08 : 8'h00);
            flash_flags = 4'b0011;
            blink_on = lv[1];
            frame(0);
        end

        // R1: reset in mid frame clears a lit output
        cur_req = "R1";
        ctrl = 8'h40; slot_idx = 0; slot_tick = 1;
        @(negedge clk);
        slot_tick = 0;
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule